// File: doc/BRIEF.md
# Inclusive Two-Level Cache Controller

This block keeps the tags, line states and line data for a small first-level data cache and a larger second-level cache that sit between a processor and a slower memory. Every line is Invalid, Shared (valid and clean) or Modified (dirty). The first level is always kept a subset of the second. When the second level throws a line out, it first removes that address from the first level. If the first level holds a newer dirty copy, that copy is pulled down before the line goes to memory.

The processor side accepts one load or store per handshake (`req_valid`/`req_ready`) and returns a one-cycle `resp_valid` pulse. The memory side issues one word-sized read or write at a time and holds it until `mem_ack`. A line is one data word and its tag is the full word address. The first-level set is the low `log2(L1_SETS)` address bits (bits [1:0] at default sizes). The second-level set is the low `log2(L2_SETS)` bits (bit [0] at default sizes). Only one miss is handled at a time.

Top module: `incl_cache_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and `resp_valid` and `mem_req` are 0. Every line in both levels is Invalid, so the first access to any address reads it from memory.
- R2: A request that hits the first level is answered with `resp_valid` in the cycle after it is accepted. It causes no memory transaction and `req_ready` stays 1.
- R3: A load (`req_write`=0) that misses both levels issues exactly one memory read (`mem_write`=0) of that address. It installs the line Shared, so a repeat load hits.
- R4: A store (`req_write`=1) that misses reads the line from memory and installs it Modified in both levels, with the store data only in the first level. A later load hits and returns the stored word. `resp_rdata` is 0 for stores.
- R5: A store that hits a Shared first-level line makes it Modified with no memory transaction, so the later eviction of that address writes the word back.
- R6: Evicting a second-level line that is Modified in either level causes one memory write (`mem_write`=1) of the victim's address. Evicting a clean line causes no write. The victim is the lowest-numbered Invalid way if one exists. Otherwise it is the set's rotating pointer, which moves to the way after the last way filled.
- R7: When the second level evicts an address, the first level drops it, so the next access to that address misses and reads memory.
- R8: The memory write of an evicted line carries the newest store data, even when that data was only in the first level.
- R9: A Modified first-level victim is written into the second level with no memory transaction. A later access finds it there without a memory read.
- R10: Every load returns the most recently stored value for its address, or the memory's initial value if that address was never stored.
- R11: From the cycle after a miss is accepted until its response, `req_ready` is 0. A miss performs at most one memory write and one memory read. `mem_req` stays high with stable address and direction until `mem_ack`.
- R12: Every valid first-level line's address is valid in the second level in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_rdata | output | DATA_W | Load data (0 for stores) |
| mem_req | output | 1 | Memory transaction request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Writeback data |
| mem_ack | input | 1 | Memory completes the transaction |
| mem_rdata | input | DATA_W | Fill data, valid with `mem_ack` |

## Verification
A wrong line state shows up at the ports in one of three ways. A dirty bit that is lost or left stale gives a writeback with old data, or none at all, when the victim is evicted. A missed back-invalidation gives a first-level hit on an address memory has moved past, so later loads return stale words. A wrong valid bit turns an expected one-cycle answer into a memory read, or the reverse. Each of these becomes visible only at the next eviction or access of the affected set. The directed sequences therefore drive each set to its eviction point right after the state change. Random traffic over twice the second-level capacity checks every load against a shadow memory.

// File: rtl/incl_cache_pkg.sv
package incl_cache_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_M = 2'd2
    } line_st_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK2,
        ST_BINV,
        ST_WB,
        ST_FETCH,
        ST_FILL1,
        ST_FILL2
    } fsm_t;

endpackage

// File: rtl/way_lookup.sv
module way_lookup #(
    parameter int WAYS = 4,
    parameter int AW   = 8,
    localparam int WI  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]         vld,
    input  logic [WAYS-1:0][AW-1:0] tags,
    input  logic [AW-1:0]           addr,
    output logic                    hit,
    output logic [WI-1:0]           way
);
    logic [WAYS-1:0] match;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == addr);
    end

    always_comb begin
        hit = |match;
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WI'(w);
        end
    end
endmodule

// File: rtl/way_victim.sv
module way_victim #(
    parameter int WAYS = 4,
    localparam int WI  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] vld,
    input  logic [WI-1:0]   ptr,
    output logic [WI-1:0]   way
);
    // free way first (lowest index), else the rotating pointer
    always_comb begin
        way = ptr;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) way = WI'(w);
        end
    end
endmodule

// File: rtl/incl_cache_ctrl.sv
module incl_cache_ctrl
    import incl_cache_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int L1_SETS = 4,
    parameter int L1_WAYS = 4,
    parameter int L2_SETS = 2,
    parameter int L2_WAYS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int L1_N  = L1_SETS * L1_WAYS;
    localparam int L2_N  = L2_SETS * L2_WAYS;
    localparam int L1_SI = $clog2(L1_SETS);
    localparam int L2_SI = $clog2(L2_SETS);
    localparam int L1_WI = $clog2(L1_WAYS);
    localparam int L2_WI = $clog2(L2_WAYS);

    typedef struct packed {
        fsm_t                                fsm;
        logic [ADDR_W-1:0]                   addr;
        logic                                wr;
        logic [DATA_W-1:0]                   wdata;
        logic [L2_WI-1:0]                    v2way;
        logic [L1_WI-1:0]                    v1way;
        logic                                rvalid;
        logic [DATA_W-1:0]                   rdata;
        logic [L1_N-1:0][1:0]                l1_st;
        logic [L1_N-1:0][ADDR_W-1:0]         l1_tag;
        logic [L1_N-1:0][DATA_W-1:0]         l1_dat;
        logic [L1_SETS-1:0][L1_WI-1:0]       l1_rr;
        logic [L2_N-1:0][1:0]                l2_st;
        logic [L2_N-1:0][ADDR_W-1:0]         l2_tag;
        logic [L2_N-1:0][DATA_W-1:0]         l2_dat;
        logic [L2_SETS-1:0][L2_WI-1:0]       l2_rr;
    } state_t;

    state_t s_q, s_d;

    logic [L1_N-1:0]             l1_vld;
    logic [L2_N-1:0]             l2_vld;
    logic [L1_N-1:0][ADDR_W-1:0] l1_tag_q;
    logic [L2_N-1:0][ADDR_W-1:0] l2_tag_q;
    logic [ADDR_W-1:0]           l1_la, l2_la;
    logic                        l1_hit, l2_hit;
    logic [L1_WI-1:0]            l1_hway, v1_pick;
    logic [L2_WI-1:0]            l2_hway, v2_pick;
    logic [L1_SI-1:0]            l1_lset, c_set1;
    logic [L2_SI-1:0]            l2_lset, c_set2;
    logic [L1_SI+L1_WI-1:0]      l1_hline, v1_line_pick, v1_line;
    logic [L2_SI+L2_WI-1:0]      l2_hline, v2_line;

    always_comb begin
        for (int i = 0; i < L1_N; i++) l1_vld[i] = (s_q.l1_st[i] != LS_I);
        for (int j = 0; j < L2_N; j++) l2_vld[j] = (s_q.l2_st[j] != LS_I);
    end

    assign l1_tag_q     = s_q.l1_tag;
    assign l2_tag_q     = s_q.l2_tag;
    assign c_set1       = s_q.addr[L1_SI-1:0];
    assign c_set2       = s_q.addr[L2_SI-1:0];
    assign v2_line      = {c_set2, s_q.v2way};
    assign v1_line_pick = {c_set1, v1_pick};
    assign v1_line      = {c_set1, s_q.v1way};

    assign l1_la = (s_q.fsm == ST_BINV) ? s_q.l2_tag[v2_line] :
                   (s_q.fsm == ST_IDLE) ? req_addr : s_q.addr;
    assign l2_la = (s_q.fsm == ST_FILL1) ? s_q.l1_tag[v1_line_pick] : s_q.addr;
    assign l1_lset  = l1_la[L1_SI-1:0];
    assign l2_lset  = l2_la[L2_SI-1:0];
    assign l1_hline = {l1_lset, l1_hway};
    assign l2_hline = {l2_lset, l2_hway};

    way_lookup #(.WAYS(L1_WAYS), .AW(ADDR_W)) u_l1_look (
        .vld (l1_vld[l1_lset*L1_WAYS +: L1_WAYS]),
        .tags(s_q.l1_tag[l1_lset*L1_WAYS +: L1_WAYS]),
        .addr(l1_la), .hit(l1_hit), .way(l1_hway)
    );
    way_lookup #(.WAYS(L2_WAYS), .AW(ADDR_W)) u_l2_look (
        .vld (l2_vld[l2_lset*L2_WAYS +: L2_WAYS]),
        .tags(s_q.l2_tag[l2_lset*L2_WAYS +: L2_WAYS]),
        .addr(l2_la), .hit(l2_hit), .way(l2_hway)
    );
    way_victim #(.WAYS(L1_WAYS)) u_l1_vict (
        .vld(l1_vld[c_set1*L1_WAYS +: L1_WAYS]), .ptr(s_q.l1_rr[c_set1]), .way(v1_pick)
    );
    way_victim #(.WAYS(L2_WAYS)) u_l2_vict (
        .vld(l2_vld[c_set2*L2_WAYS +: L2_WAYS]), .ptr(s_q.l2_rr[c_set2]), .way(v2_pick)
    );

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;
        unique case (s_q.fsm)
            ST_IDLE: begin
                if (req_valid) begin
                    if (l1_hit) begin
                        s_d.rvalid = 1'b1;
                        s_d.rdata  = req_write ? '0 : s_q.l1_dat[l1_hline];
                        if (req_write) begin
                            s_d.l1_dat[l1_hline] = req_wdata;
                            s_d.l1_st[l1_hline]  = LS_M;
                        end
                    end else begin
                        s_d.addr  = req_addr;
                        s_d.wr    = req_write;
                        s_d.wdata = req_wdata;
                        s_d.fsm   = ST_CHK2;
                    end
                end
            end
            ST_CHK2: begin
                if (l2_hit) begin
                    s_d.fsm = ST_FILL1;
                end else begin
                    s_d.v2way = v2_pick;
                    s_d.fsm   = l2_vld[{c_set2, v2_pick}] ? ST_BINV : ST_FETCH;
                end
            end
            ST_BINV: begin
                s_d.fsm = (s_q.l2_st[v2_line] == LS_M) ? ST_WB : ST_FETCH;
                if (l1_hit) begin
                    s_d.l1_st[l1_hline] = LS_I;
                    if (s_q.l1_st[l1_hline] == LS_M) begin
                        s_d.l2_dat[v2_line] = s_q.l1_dat[l1_hline];
                        s_d.l2_st[v2_line]  = LS_M;
                        s_d.fsm             = ST_WB;
                    end
                end
            end
            ST_WB: begin
                if (mem_ack) s_d.fsm = ST_FETCH;
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    s_d.l2_tag[v2_line] = s_q.addr;
                    s_d.l2_dat[v2_line] = mem_rdata;
                    s_d.l2_st[v2_line]  = s_q.wr ? LS_M : LS_S;
                    s_d.l2_rr[c_set2]   = s_q.v2way + L2_WI'(1);
                    s_d.fsm             = ST_FILL1;
                end
            end
            ST_FILL1: begin
                s_d.v1way = v1_pick;
                if (l1_vld[v1_line_pick] && s_q.l1_st[v1_line_pick] == LS_M && l2_hit) begin
                    s_d.l2_dat[l2_hline] = s_q.l1_dat[v1_line_pick];
                    s_d.l2_st[l2_hline]  = LS_M;
                end
                s_d.fsm = ST_FILL2;
            end
            ST_FILL2: begin
                s_d.l1_tag[v1_line] = s_q.addr;
                s_d.l1_rr[c_set1]   = s_q.v1way + L1_WI'(1);
                s_d.rvalid          = 1'b1;
                if (s_q.wr) begin
                    s_d.l1_dat[v1_line] = s_q.wdata;
                    s_d.l1_st[v1_line]  = LS_M;
                    s_d.l2_st[l2_hline] = LS_M;
                    s_d.rdata           = '0;
                end else begin
                    s_d.l1_dat[v1_line] = s_q.l2_dat[l2_hline];
                    s_d.l1_st[v1_line]  = LS_S;
                    s_d.rdata           = s_q.l2_dat[l2_hline];
                end
                s_d.fsm = ST_IDLE;
            end
            default: s_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_ready  = (s_q.fsm == ST_IDLE);
    assign resp_valid = s_q.rvalid;
    assign resp_rdata = s_q.rdata;
    assign mem_req    = (s_q.fsm == ST_WB) || (s_q.fsm == ST_FETCH);
    assign mem_write  = (s_q.fsm == ST_WB);
    assign mem_addr   = (s_q.fsm == ST_WB) ? s_q.l2_tag[v2_line] : s_q.addr;
    assign mem_wdata  = s_q.l2_dat[v2_line];
endmodule

// File: rtl/incl_cache_ctrl_chk.sv
module incl_cache_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int L1_N   = 16,
    parameter int L2_N   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_ready,
    input logic                    resp_valid,
    input logic                    mem_req,
    input logic                    mem_ack,
    input logic                    mem_write,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [L1_N-1:0]         l1_vld,
    input logic [L1_N-1:0][ADDR_W-1:0] l1_tag,
    input logic [L2_N-1:0]         l2_vld,
    input logic [L2_N-1:0][ADDR_W-1:0] l2_tag
);
    logic [L1_N-1:0] has_home;

    always_comb begin
        for (int i = 0; i < L1_N; i++) begin
            has_home[i] = !l1_vld[i];
            for (int j = 0; j < L2_N; j++) begin
                if (l1_vld[i] && l2_vld[j] && (l2_tag[j] == l1_tag[i])) has_home[i] = 1'b1;
            end
        end
    end

    // R12
    inclusion_chk: assert property (@(posedge clk) disable iff (!rst_n) &has_home);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_write));

    // R11
    single_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R2
    resp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && $past(req_ready) |-> $past(req_valid));
endmodule

bind incl_cache_ctrl incl_cache_ctrl_chk #(
    .ADDR_W(ADDR_W), .L1_N(L1_N), .L2_N(L2_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_write(mem_write), .mem_addr(mem_addr),
    .l1_vld(l1_vld), .l1_tag(l1_tag_q), .l2_vld(l2_vld), .l2_tag(l2_tag_q)
);

// File: tb/incl_cache_ctrl_bench.sv
module incl_cache_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, resp_valid, mem_req, mem_write;
    logic [15:0] resp_rdata, mem_wdata;
    logic [7:0]  mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    logic [15:0] mem [256];
    logic [15:0] sh  [256];
    int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
    logic [7:0]  last_rd_addr, last_wr_addr;
    logic [15:0] last_wr_data;
    bit done = 0;

    incl_cache_ctrl u_incl_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata), .mem_req(mem_req),
        .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    initial forever #10 clk = ~clk;

    function automatic logic [15:0] init_val(input logic [7:0] a);
        return {a, a ^ 8'h5A};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // memory responder
    initial begin
        for (int a = 0; a < 256; a++) begin
            mem[a] = init_val(8'(a));
            sh[a]  = init_val(8'(a));
        end
        forever begin
            @(negedge clk);
            if (mem_req && rst_n) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                mem_ack = 1'b1;
                if (mem_write) begin
                    mem[mem_addr] = mem_wdata;
                    n_wr++;
                    last_wr_addr = mem_addr;
                    last_wr_data = mem_wdata;
                end else begin
                    mem_rdata = mem[mem_addr];
                    n_rd++;
                    last_rd_addr = mem_addr;
                end
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic access(input logic wr, input logic [7:0] a, input logic [15:0] d,
                          output logic [15:0] got, output int lat,
                          output int drd, output int dwr);
        int rd0, wr0;
        bit acc, bad;
        rd0 = n_rd; wr0 = n_wr; bad = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        acc = 0;
        while (!acc) begin
            acc = req_ready;
            @(negedge clk);
        end
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 200) begin
            if (req_ready) bad = 1;
            @(negedge clk);
            lat++;
        end
        got = resp_rdata;
        if (wr) sh[a] = d;
        drd = n_rd - rd0;
        dwr = n_wr - wr0;
        chk(!bad, "R11", "req_ready high during miss", 32'(bad), 0);
        chk(resp_valid, "R11", "response arrived", 32'(resp_valid), 1);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [15:0] got, d1, d2, d3;
        int lat, drd, dwr;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(req_ready && !resp_valid && !mem_req, "R1", "idle outputs after reset",
            {req_ready, resp_valid, mem_req}, 3'b100);

        // R1 R3: load miss
        access(0, 8'h10, 0, got, lat, drd, dwr);
        chk(drd == 1 && last_rd_addr == 8'h10, "R3", "one read of miss address", last_rd_addr, 8'h10);
        chk(dwr == 0, "R3", "no write on clean fill", dwr, 0);
        chk(got == init_val(8'h10), "R3", "load miss data", got, init_val(8'h10));
        // R2: hit
        access(0, 8'h10, 0, got, lat, drd, dwr);
        chk(lat == 1 && drd == 0 && dwr == 0, "R2", "hit latency/no traffic", lat, 1);

        // R4: store miss
        d1 = 16'hBEEF;
        access(1, 8'h11, d1, got, lat, drd, dwr);
        chk(drd == 1 && dwr == 0 && lat > 1, "R4", "store miss fetch", {drd[15:0], dwr[15:0]}, 32'h10000);
        chk(got == 0, "R4", "store response data", got, 0);
        access(0, 8'h11, 0, got, lat, drd, dwr);
        chk(lat == 1 && got == d1, "R4", "load after store miss", got, d1);

        // R5: store hit on Shared
        d2 = 16'h1234;
        access(1, 8'h10, d2, got, lat, drd, dwr);
        chk(lat == 1 && drd == 0 && dwr == 0, "R5", "upgrade without traffic", lat, 1);

        // R6: fill remaining ways of second-level set 0 without writebacks
        for (int k = 0; k < 7; k++) begin
            access(0, 8'(8'h02 + 4 * k), 0, got, lat, drd, dwr);
            chk(dwr == 0 && drd == 1, "R6", "free way fill", dwr, 0);
        end
        // R8: evicting 0x10 recalls the dirty first-level copy
        access(0, 8'h1E, 0, got, lat, drd, dwr);
        chk(dwr == 1 && last_wr_addr == 8'h10, "R6", "dirty victim written", last_wr_addr, 8'h10);
        chk(last_wr_data == d2, "R8", "recalled data", last_wr_data, d2);
        // R7: back-invalidated line misses; next victim 0x02 is clean
        access(0, 8'h10, 0, got, lat, drd, dwr);
        chk(drd == 1 && last_rd_addr == 8'h10, "R7", "re-access misses", drd, 1);
        chk(dwr == 0, "R6", "clean victim no write", dwr, 0);
        chk(got == d2, "R10", "data after round trip", got, d2);

        // R9: dirty first-level victim goes into second level only
        d3 = 16'hC0DE;
        begin
            int wr0;
            wr0 = n_wr;
            access(1, 8'h03, d3, got, lat, drd, dwr);
            for (int k = 1; k <= 4; k++) access(0, 8'(8'h03 + 4 * k), 0, got, lat, drd, dwr);
            chk(n_wr == wr0, "R9", "no memory write on L1 eviction", n_wr - wr0, 0);
        end
        access(0, 8'h03, 0, got, lat, drd, dwr);
        chk(drd == 0 && lat > 1, "R9", "served from second level", drd, 0);
        chk(got == d3, "R9", "data kept", got, d3);

        // R10: random traffic
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            logic wr;
            logic [15:0] d;
            a  = 8'($urandom_range(0, 31));
            wr = ($urandom_range(0, 2) == 0);
            d  = 16'($urandom);
            access(wr, a, d, got, lat, drd, dwr);
            if (!wr) chk(got == sh[a], "R10", "random load", got, sh[a]);
            if (lat == 1) chk(drd == 0 && dwr == 0, "R2", "hit without traffic", drd + dwr, 0);
            chk(drd <= 1 && dwr <= 1, "R11", "one txn each way per miss", {drd[15:0], dwr[15:0]}, 32'h10001);
        end
        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule